// File: doc/BRIEF.md
# Programmable DRAM Refresh Scheduler

This block tells a DRAM memory sequencer when a refresh cycle is due. A free-running prescaler divides the system clock by sixteen times one more than a 6-bit divider field, which is taken from the configuration word. Each time the prescaler expires, the block owes the memory one more row refresh. The sequencer sees a request whenever at least one refresh is owed. Each acknowledge it returns pays one refresh back.

While the sequencer is in the middle of a burst, the request is withheld so that the burst is never cut short. The prescaler keeps running during that time, and the debt keeps growing in a saturating counter. When the burst ends, the deferred refreshes are issued back to back. This keeps the time to refresh the whole device bounded. If the debt reaches the counter's ceiling, an urgent flag tells the sequencer to close the burst early.

Top module: `refresh_scheduler`

## Requirements
- R1: The refresh interval is 16 × (D + 1) clock cycles, where D is the divider field. After reset is released, the first owed refresh makes the request visible exactly 16 × (D + 1) rising edges later.
- R2: D is the unsigned value of configuration bits 13 (most significant) down to 8. All other configuration bits have no effect on the outputs.
- R3: Each interval expiry adds one to the owed count, and each accepted acknowledge subtracts one. An acknowledge is accepted when `refAck` is high in a cycle where `refReq` is high. `refReq` is high exactly when the owed count is nonzero and `burstActive` is low.
- R4: While `burstActive` is high, `refReq` is low, but interval expiries keep adding to the owed count. When the burst ends, the request is raised in the same cycle if anything is owed.
- R5: An acknowledge while `refReq` is low is ignored. This includes an acknowledge during a burst or while nothing is owed.
- R6: The owed count saturates at 15. Further expiries are dropped, and the count never wraps to zero.
- R7: `refUrgent` is high exactly when the owed count equals 15.
- R8: Any change of D restarts the prescaler from zero on the next edge. No expiry is counted in that cycle, so the next request comes a full new interval later.
- R9: Synchronous active-low reset clears the owed count and the prescaler. During reset both outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfgWord | input | 16 | Configuration word; bits 13:8 hold the divider field |
| burstActive | input | 1 | High while the sequencer runs a burst |
| refAck | input | 1 | Sequencer accepts the pending refresh |
| refReq | output | 1 | A refresh is owed and may be performed now |
| refUrgent | output | 1 | Owed count is at its ceiling; burst should end |

## Verification
The embedded properties are checked on every cycle. They cover these points:
- Two interval expiries are never adjacent.
- An acknowledge is consumed only when a refresh is owed.
- An acknowledge without a coincident expiry lowers the debt by one.
- A saturated count does not wrap.
- An urgent flag outside a burst always comes with a request.

Only the bench scenarios can show the following:
- The exact interval lengths for several divider values, including the 400-cycle case.
- The restart after a divider change.
- That the bits outside the divider field have no effect.
- The deferral and drain around bursts, checked against a cycle-by-cycle model.

// File: rtl/refresh_sched_pkg.sv
package refresh_sched_pkg;
  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic reload;   // divider changed: restart prescaler
    logic consume;  // an acknowledged refresh retires one owed row
  } schedStrobe_t;
endpackage

// File: rtl/refresh_ctl.sv
module refresh_ctl
  import refresh_sched_pkg::*;
#(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divField,
  input  logic             burstActive,
  input  logic             refAck,
  input  logic             owedNonZero,
  output schedStrobe_t     strobe,
  output logic             refReq
);
  logic [DIV_W-1:0] divPrev;

  // During reset, track the field so that no spurious reload follows release
  always_ff @(posedge clk) begin
    divPrev <= divField;
  end

  always_comb begin
    refReq         = owedNonZero && !burstActive;
    strobe.reload  = rst_n && (divField != divPrev);
    strobe.consume = refReq && refAck;
  end
endmodule

// File: rtl/refresh_dp.sv
module refresh_dp
  import refresh_sched_pkg::*;
#(
  parameter int DIV_W      = 6,
  parameter int TICK_SHIFT = 4,
  parameter int OWED_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divField,
  input  schedStrobe_t     strobe,
  output logic             owedNonZero,
  output logic             owedFull
);
  localparam int PRE_W = DIV_W + TICK_SHIFT;
  localparam logic [OWED_W-1:0] OWED_MAX = '1;

  logic [PRE_W-1:0]  preCnt;
  logic [PRE_W-1:0]  periodLast;
  logic [OWED_W-1:0] owedCnt;
  logic              tick;

  // Last count value of one interval: ((D + 1) << shift) - 1, modulo 2^PRE_W
  always_comb begin
    periodLast = ((PRE_W'(divField) + PRE_W'(1)) << TICK_SHIFT) - PRE_W'(1);
    tick       = !strobe.reload && (preCnt == periodLast);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                     preCnt <= '0;
    else if (strobe.reload || tick) preCnt <= '0;
    else                            preCnt <= preCnt + PRE_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owedCnt <= '0;
    end else begin
      unique case ({tick, strobe.consume})
        2'b10:   if (owedCnt != OWED_MAX) owedCnt <= owedCnt + OWED_W'(1);
        2'b01:   owedCnt <= owedCnt - OWED_W'(1);
        default: owedCnt <= owedCnt;
      endcase
    end
  end

  assign owedNonZero = (owedCnt != '0);
  assign owedFull    = (owedCnt == OWED_MAX);

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);                                                   // R1
  AST_ACK_NEEDS_DEBT: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.consume |-> owedCnt != '0);                                 // R5
  AST_ACK_DECREMENTS: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.consume && !tick) |=> owedCnt == $past(owedCnt) - OWED_W'(1)); // R3
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (owedCnt == OWED_MAX && !strobe.consume) |=> owedCnt == OWED_MAX);   // R6
endmodule

// File: rtl/refresh_scheduler.sv
module refresh_scheduler
  import refresh_sched_pkg::*;
#(
  parameter int CFG_W      = 16,
  parameter int DIV_LSB    = 8,
  parameter int DIV_W      = 6,
  parameter int TICK_SHIFT = 4,
  parameter int OWED_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfgWord,
  input  logic             burstActive,
  input  logic             refAck,
  output logic             refReq,
  output logic             refUrgent
);
  localparam int DIV_MSB = DIV_LSB + DIV_W - 1;

  logic [DIV_W-1:0] divField;
  logic             owedNonZero;
  logic             owedFull;
  schedStrobe_t     strobe;

  assign divField = cfgWord[DIV_MSB:DIV_LSB];

  refresh_ctl #(.DIV_W(DIV_W)) ctlInst (
    .clk(clk), .rst_n(rst_n), .divField(divField), .burstActive(burstActive),
    .refAck(refAck), .owedNonZero(owedNonZero), .strobe(strobe), .refReq(refReq)
  );

  refresh_dp #(.DIV_W(DIV_W), .TICK_SHIFT(TICK_SHIFT), .OWED_W(OWED_W)) dpInst (
    .clk(clk), .rst_n(rst_n), .divField(divField), .strobe(strobe),
    .owedNonZero(owedNonZero), .owedFull(owedFull)
  );

  assign refUrgent = owedFull;

  AST_URGENT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (refUrgent && !burstActive) |-> refReq);                           // R7
endmodule

// File: tb/refresh_scheduler_test.sv
`timescale 1ns/1ps
module refresh_scheduler_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfgWord = '0;
  logic        burst = 1'b0;
  logic        ack = 1'b0;
  logic        refReq, refUrgent;
  int          checks = 0, errors = 0;
  int          curDiv = 0;
  int          mCnt = 0, mOwed = 0, mPrev = 0;

  always #2.5 clk = ~clk;

  refresh_scheduler uut (
    .clk(clk), .rst_n(rst_n), .cfgWord(cfgWord), .burstActive(burst),
    .refAck(ack), .refReq(refReq), .refUrgent(refUrgent)
  );

  // Reference model built from R1..R9
  always @(posedge clk) begin : model
    int div, period;
    bit change, tick, cons;
    div = int'(cfgWord[13:8]);
    if (!rst_n) begin
      mCnt = 0; mOwed = 0; mPrev = div;
    end else begin
      change = (div != mPrev);
      period = 16 * (div + 1);
      tick   = !change && (mCnt == period - 1);
      cons   = (mOwed != 0) && !burst && ack;
      if (tick && !cons) begin
        if (mOwed < 15) mOwed++;
      end else if (!tick && cons) mOwed--;
      mCnt  = (change || tick) ? 0 : mCnt + 1;
      mPrev = div;
    end
  end

  function automatic logic expReq(int owed, logic b);
    return (owed != 0) && !b;
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare against the model, then scramble the bits outside the field (R2)
  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (rst_n) begin
        chk("R3 model refReq", refReq, expReq(mOwed, burst));
        chk("R7 model refUrgent", refUrgent, mOwed == 15);
      end
      cfgWord = {2'($urandom), 6'(curDiv), 8'($urandom)};
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 1'b0;
    cfgWord = {2'b0, 6'(curDiv), 8'h5A};
    repeat (3) @(negedge clk);
    chk("R9 reset refReq", refReq, 1'b0);
    chk("R9 reset refUrgent", refUrgent, 1'b0);
    rst_n = 1'b1;
  endtask

  initial begin
    #(5.0 * 300000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    // R1/R2: divider 0 -> 16 cycles, with junk on other bits
    curDiv = 0; burst = 0; ack = 0;
    doReset();
    step(15); chk("R1 no request before 16", refReq, 1'b0);
    step(1);  chk("R1 request at 16", refReq, 1'b1);
    ack = 1;
    step(1);  chk("R3 ack retires debt", refReq, 1'b0);
    // R1: divider 24 -> 400 cycles
    curDiv = 24;
    doReset();
    step(399); chk("R1 no request before 400", refReq, 1'b0);
    step(1);   chk("R1 request at 400", refReq, 1'b1);
    // R8: divider change restarts prescaler
    curDiv = 1; ack = 0;
    doReset();
    step(20);
    curDiv = 0;
    cfgWord = {2'b0, 6'(curDiv), 8'h00};
    step(16); chk("R8 no request before new interval", refReq, 1'b0);
    step(1);  chk("R8 request after new interval", refReq, 1'b1);
    // R4/R5/R6/R7: saturate during burst with ack held high
    curDiv = 0; burst = 1; ack = 1;
    doReset();
    step(239); chk("R7 not urgent at 14", refUrgent, 1'b0);
               chk("R4 held off in burst", refReq, 1'b0);
    step(1);   chk("R7 urgent at 15", refUrgent, 1'b1);
    step(100); chk("R6 saturated no wrap", refUrgent, 1'b1);
               chk("R5 ack in burst ignored", refReq, 1'b0);
    burst = 0;
    #1;        chk("R4 request at burst end", refReq, 1'b1);
    step(40);  chk("R7 urgent cleared after drain", refUrgent, 1'b0);
    // R5: ack while nothing owed
    ack = 1;
    doReset();
    step(10);  chk("R5 ack with no debt ignored", refReq, 1'b0);
    // Constrained random with occasional resets (R9)
    for (int seg = 0; seg < 200; seg++) begin
      curDiv = ($urandom % 8 == 0) ? int'($urandom % 64) : int'($urandom % 4);
      if (seg % 25 == 0) doReset();
      for (int c = 0; c < 150; c++) begin
        burst = ($urandom % 100) < 35;
        ack   = ($urandom % 100) < 60;
        step(1);
      end
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule